// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 20-bit virtual page number into a physical page number. It reads a two-level page table out of byte-addressed memory, one 32-bit word at a time, over a request/response port. A caller presents a VPN together with the base address of the page directory. The walker first reads the directory word selected by the upper half of the VPN. If that word is a non-null pointer, it then reads the page table entry selected by the lower half of the VPN from the table that the pointer locates. The walker never writes memory.

Each entry word holds a 20-bit PPN in bits 19:0, Ref in bit 20, Dirty in bit 21, Valid in bit 22 and Alloc in bit 23. Bits 31:24 are not interpreted. Each walk ends with a single-cycle completion pulse that carries one of three outcomes: a usable translation, a page that exists but is not resident, or an access to a page that does not exist. On a translation the PPN and the four status bits come back unchanged, ready to be loaded into a TLB. A VPN outside the user range is rejected at once, without touching memory.

Top module: `pt_walker`

## Requirements
- R1: After reset `done` and `mem_req_valid` are low and `req_ready` is high.
- R2: A VPN greater than 0xBFFFF that is accepted produces `done` with result 2 (illegal) on the clock edge after acceptance, and no memory read is issued for it.
- R3: For an in-range VPN, the first read is at byte address `dir_base + VPN[19:10]*4`.
- R4: If the directory word read back is all zero, the walk ends with result 2 after exactly one read.
- R5: Otherwise the second and last read is at byte address `pointer + VPN[9:0]*4`, where `pointer` is the directory word.
- R6: An entry with bit 23 (Alloc) set and bit 22 (Valid) set gives result 0. `ppn` equals entry bits 19:0, and `flags` equals entry bits 23:20 in the order {Alloc, Valid, Dirty, Ref}.
- R7: An entry with Alloc set and Valid clear gives result 1 (page fault), with `ppn` and `flags` both zero.
- R8: An entry with Alloc clear gives result 2 (illegal), whatever its Valid bit, with `ppn` and `flags` both zero.
- R9: `done` is high for exactly one cycle per walk. `req_ready` is high only while no walk is in progress and `done` is low.
- R10: A memory request holds `mem_req_valid` and `mem_req_addr` steady until the cycle in which `mem_req_ready` is high. Any number of cycles may pass between acceptance and `mem_rsp_valid`.
- R11: Entry bits 31:24 have no effect on result, `ppn` or `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vpn | input | 20 | Virtual page number to translate |
| dir_base | input | 32 | Byte address of the page directory, sampled at acceptance |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 translation, 1 page fault, 2 illegal |
| ppn | output | 20 | Physical page number (zero unless result is 0) |
| flags | output | 4 | {Alloc, Valid, Dirty, Ref} of the entry (zero unless result is 0) |

## Verification
The properties assume that memory answers each accepted read with exactly one `mem_rsp_valid` pulse, and never pulses it while no read is outstanding. They also assume that reset is held from time zero. The bench memory model keeps to this: it records one pending read at a handshake, returns it after a random delay of zero to two cycles, and drops `mem_rsp_valid` at all other times. Its random readiness only affects how long a request is held. The directory and the tables live inside a small modelled region, so that every pointer the walker follows lands on words the bench has defined.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    PTW_XLATE   = 2'd0,
    PTW_FAULT   = 2'd1,
    PTW_ILLEGAL = 2'd2
  } ptw_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_PTE_REQ,
    ST_PTE_WAIT
  } ptw_state_e;

  // status bit offsets above the PPN field
  localparam int FLG_REF   = 0;
  localparam int FLG_DIRTY = 1;
  localparam int FLG_VALID = 2;
  localparam int FLG_ALLOC = 3;
  localparam int FLG_W     = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - IDX_W - 2;

  // word index scaled to a byte offset
  assign addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PPN_W  = 20
) (
  input  logic [DATA_W-1:0] pte,
  output ptw_res_e          res,
  output logic [PPN_W-1:0]  ppn,
  output logic [FLG_W-1:0]  flags
);
  localparam int FLG_LO = PPN_W;
  localparam int FLG_HI = PPN_W + FLG_W - 1;

  logic [FLG_W-1:0] raw_flags;
  logic             unused_hi;

  assign raw_flags = pte[FLG_HI:FLG_LO];
  assign unused_hi = ^pte[DATA_W-1:FLG_HI+1];

  always_comb begin
    res   = PTW_ILLEGAL;
    ppn   = '0;
    flags = '0;
    if (raw_flags[FLG_ALLOC]) begin
      if (raw_flags[FLG_VALID]) begin
        res   = PTW_XLATE;
        ppn   = pte[PPN_W-1:0];
        flags = raw_flags;
      end else begin
        res = PTW_FAULT;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VPN_W     = 20,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DIR_IDX_W = 10,
  parameter logic [VPN_W-1:0] VPN_LIMIT = 20'hBFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [1:0]        result,
  output logic [VPN_W-1:0]  ppn,
  output logic [3:0]        flags
);
  localparam int TBL_IDX_W = VPN_W - DIR_IDX_W;
  localparam int PPN_W     = VPN_W;

  ptw_state_e        state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mreq_q;
  logic              done_q;
  ptw_res_e          res_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [FLG_W-1:0]  flags_q;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;
  ptw_res_e          dec_res;
  logic [PPN_W-1:0]  dec_ppn;
  logic [FLG_W-1:0]  dec_flags;
  logic              accept;
  logic              ptr_null;

  // directory word address from the live request
  ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(DIR_IDX_W)) u_dir_addr (
    .base (dir_base),
    .idx  (req_vpn[VPN_W-1:TBL_IDX_W]),
    .addr (dir_addr)
  );

  // entry address from the pointer as it returns
  ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(TBL_IDX_W)) u_tbl_addr (
    .base (mem_rsp_data[ADDR_W-1:0]),
    .idx  (vpn_q[TBL_IDX_W-1:0]),
    .addr (tbl_addr)
  );

  ptw_pte_decode #(.DATA_W(DATA_W), .PPN_W(PPN_W)) u_decode (
    .pte   (mem_rsp_data),
    .res   (dec_res),
    .ppn   (dec_ppn),
    .flags (dec_flags)
  );

  assign req_ready = (state_q == ST_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;
  assign ptr_null  = (mem_rsp_data == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      addr_q  <= '0;
      mreq_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= PTW_XLATE;
      ppn_q   <= '0;
      flags_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            vpn_q <= req_vpn;
            if (req_vpn > VPN_LIMIT) begin
              done_q  <= 1'b1;
              res_q   <= PTW_ILLEGAL;
              ppn_q   <= '0;
              flags_q <= '0;
            end else begin
              addr_q  <= dir_addr;
              mreq_q  <= 1'b1;
              state_q <= ST_DIR_REQ;
            end
          end
        end
        ST_DIR_REQ: begin
          if (mem_req_ready) begin
            mreq_q  <= 1'b0;
            state_q <= ST_DIR_WAIT;
          end
        end
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            if (ptr_null) begin
              done_q  <= 1'b1;
              res_q   <= PTW_ILLEGAL;
              ppn_q   <= '0;
              flags_q <= '0;
              state_q <= ST_IDLE;
            end else begin
              addr_q  <= tbl_addr;
              mreq_q  <= 1'b1;
              state_q <= ST_PTE_REQ;
            end
          end
        end
        ST_PTE_REQ: begin
          if (mem_req_ready) begin
            mreq_q  <= 1'b0;
            state_q <= ST_PTE_WAIT;
          end
        end
        ST_PTE_WAIT: begin
          if (mem_rsp_valid) begin
            done_q  <= 1'b1;
            res_q   <= dec_res;
            ppn_q   <= dec_ppn;
            flags_q <= dec_flags;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = addr_q;
  assign done          = done_q;
  assign result        = res_q;
  assign ppn           = ppn_q;
  assign flags         = flags_q;

endmodule

// File: rtl/ptw_check.sv
module ptw_check #(
  parameter int VPN_W  = 20,
  parameter int ADDR_W = 32,
  parameter logic [VPN_W-1:0] VPN_LIMIT = 20'hBFFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VPN_W-1:0]  req_vpn,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done,
  input logic [1:0]        result,
  input logic [VPN_W-1:0]  ppn,
  input logic [3:0]        flags
);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r2_range_illegal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_vpn > VPN_LIMIT)) |=> (done && result == 2'd2 && !mem_req_valid));

  a_r6_xlate_flags: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'd0) |-> (flags[3:2] == 2'b11));

  a_r8_no_ppn_on_reject: assert property (@(posedge clk) disable iff (rst)
    (done && result != 2'd0) |-> (ppn == '0 && flags == 4'd0));

  a_r7_code_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'd3));

endmodule

bind pt_walker ptw_check #(
  .VPN_W(VPN_W), .ADDR_W(ADDR_W), .VPN_LIMIT(VPN_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vpn(req_vpn), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .result(result), .ppn(ppn), .flags(flags)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam logic [31:0] DIR_BASE = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic [31:0] dir_base = DIR_BASE;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  result;
  logic [19:0] ppn;
  logic [3:0]  flags;

  logic [31:0] mem [0:8191];
  int          errors = 0;
  int          checks = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [0:1];
  bit          pend = 0;
  int          pcnt = 0;
  logic [31:0] paddr = '0;

  always #5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .dir_base(dir_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .result(result), .ppn(ppn), .flags(flags)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one outstanding read, random delay and readiness
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[paddr[14:2]];
          pend = 0;
        end else pcnt--;
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready && !pend) begin
        pend  = 1;
        paddr = mem_req_addr;
        pcnt  = $urandom % 3;
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  // reference outcome built from the requirements
  task automatic expect_walk(input logic [19:0] v, output logic [1:0] r, output logic [19:0] p,
                             output logic [3:0] f, output int nrd, output logic [31:0] ptr, output string tag);
    logic [31:0] pte;
    r = 2'd2; p = '0; f = '0; ptr = '0;
    if (v > 20'hBFFFF) begin nrd = 0; tag = "R2"; return; end
    ptr = mem[(DIR_BASE + {20'd0, v[19:10], 2'b00}) >> 2];
    if (ptr == 0) begin nrd = 1; tag = "R4"; return; end
    nrd = 2;
    pte = mem[(ptr + {20'd0, v[9:0], 2'b00}) >> 2];
    if (!pte[23]) tag = "R8";
    else if (!pte[22]) begin r = 2'd1; tag = "R7"; end
    else begin r = 2'd0; p = pte[19:0]; f = pte[23:20]; tag = "R6_R11"; end
  endtask

  task automatic walk(input logic [19:0] v);
    logic [1:0] er; logic [19:0] ep; logic [3:0] ef; int en; logic [31:0] eptr; string tag;
    int n;
    expect_walk(v, er, ep, ef, en, eptr, tag);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1;
    req_vpn = v;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(done, {tag, " done seen"}, {31'd0, done}, 32'd1);
    check(result == er, {tag, " result"}, {30'd0, result}, {30'd0, er});
    check(ppn == ep, {tag, " ppn"}, {12'd0, ppn}, {12'd0, ep});
    check(flags == ef, {tag, " flags"}, {28'd0, flags}, {28'd0, ef});
    check(rd_cnt == en, {tag, " read count"}, rd_cnt, en);
    if (en >= 1)
      check(rd_addr[0] == DIR_BASE + {20'd0, v[19:10], 2'b00}, "R3 dir addr",
            rd_addr[0], DIR_BASE + {20'd0, v[19:10], 2'b00});
    if (en == 2)
      check(rd_addr[1] == eptr + {20'd0, v[9:0], 2'b00}, "R5 pte addr",
            rd_addr[1], eptr + {20'd0, v[9:0], 2'b00});
    @(negedge clk);
    check(!done, "R9 single-cycle done", {31'd0, done}, 32'd0);
    check(req_ready, "R9 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    for (int i = 0; i < 1024; i++) begin
      int k;
      k = $urandom % 4;
      mem[(DIR_BASE >> 2) + i] = (k == 0) ? 32'd0 : (32'h1000 * k);
    end
    for (int i = 1024; i < 4096; i++) begin
      logic [31:0] w;
      int k;
      w = $urandom;
      k = $urandom % 4;
      case (k)
        0: w = '0;
        1: w[23] = 1'b0;
        2: begin w[23] = 1'b1; w[22] = 1'b0; end
        default: begin w[23] = 1'b1; w[22] = 1'b1; end
      endcase
      mem[i] = w;
    end
    // directed layout
    mem[(DIR_BASE >> 2) + 10'h2FF] = 32'h0000_3000;
    mem[(32'h3000 >> 2) + 10'h3FF] = 32'hA0E1_2345;
    mem[(DIR_BASE >> 2) + 0] = 32'h0000_1000;
    mem[(32'h1000 >> 2) + 0] = 32'h0000_0000;
    mem[(32'h1000 >> 2) + 1] = 32'h004A_BCDE;
    mem[(32'h1000 >> 2) + 2] = 32'h00B5_4321;
    mem[(32'h1000 >> 2) + 3] = 32'hFFF0_0001;
    mem[(DIR_BASE >> 2) + 5] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done, "R1 done low", {31'd0, done}, 32'd0);
    check(!mem_req_valid, "R1 no request", {31'd0, mem_req_valid}, 32'd0);
    check(req_ready, "R1 ready high", {31'd0, req_ready}, 32'd1);

    walk(20'hBFFFF);   // R6 top of range, R11 reserved bits set
    walk(20'hC0000);   // R2 just above range
    walk(20'hFFFFF);   // R2
    walk(20'h00000);   // R8 all-zero entry
    walk(20'h00001);   // R8 alloc clear, valid set
    walk(20'h00002);   // R7
    walk(20'h00003);   // R6 with all reserved bits set (R11)
    walk(20'h01405);   // R4 null pointer
    for (int i = 0; i < 150; i++) begin
      logic [19:0] v;
      v = (($urandom % 8) == 0) ? 20'(20'hC0000 + ($urandom % 20'h40000))
                                : 20'($urandom % 20'hC0000);
      walk(v);     // R10 random readiness and delay on every walk
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule